// File: doc/BRIEF.md
# Debug Session and Single-Step Controller

This block sits between a decoded debug command path and a processor core. When an external debug request arrives, it asks the core to stop. The core finishes its current instruction, saves its pipeline state and reports that it has done so. From then on the core is held in debug state, and the controller accepts two go commands:

- A go-and-stay command releases the core for exactly one instruction. The core then returns to debug state and the session stays open.
- A go-and-exit command closes the session and resumes the core in the power state it had before entry.

Every go command must be preceded by a fresh load of the core's scan register. A go command without such a load is dropped and flagged.

The controller drives a wake line for the whole session. This pulls the chip out of wait, stop or halt so the core can answer the request. The saved power state is presented to the core on resume. Accesses to resources inside the debug logic do not involve this block, so the core keeps running during them.

Top module: `dbg_session_ctrl`

## Requirements
- R1: After the asynchronous reset, every output is low and `resume_pwr` is 0.
- R2: When `ext_dbg_req` is high while no session is open, then from the next cycle `dbg_req`, `st_session` and `wake` are high. The power state sampled in that cycle is held on `resume_pwr`. The encoding is 0 running, 1 waiting, 2 stopped, 3 halted.
- R3: `dbg_req` stays high until `core_pipe_saved` is seen. In the following cycle `dbg_req` is low and `st_in_debug` is high.
- R4: In debug state, an accepted go-and-stay produces a one-cycle `core_step` pulse. It also sets `st_stepping` and clears `st_in_debug` until `core_insn_done`, after which `st_in_debug` returns. `st_session` stays high throughout.
- R5: A go command in debug state with no scan load since the last accepted go is ignored and sets the sticky `st_go_err`. The next `scan_loaded` clears it.
- R6: An accepted go-and-exit with `ext_dbg_req` low produces a one-cycle `core_resume` pulse and ends the session. In that cycle `st_session`, `st_in_debug` and `wake` go low, and `resume_pwr` still shows the power state saved at entry.
- R7: An accepted go-and-exit while `ext_dbg_req` is high keeps the core in debug state with no `core_resume` pulse. It still consumes the scan load.
- R8: A go command while the core is not in debug state has no effect and does not set `st_go_err`.
- R9: When both go strobes arrive in the same cycle, the exit command takes priority.
- R10: `wake` is high in every cycle in which `st_session` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous test reset, active low |
| cmd_go_stay | input | 1 | Go-and-stay (single step) command strobe |
| cmd_go_exit | input | 1 | Go-and-exit command strobe |
| scan_loaded | input | 1 | Core scan register was loaded |
| ext_dbg_req | input | 1 | External debug request, level |
| core_insn_done | input | 1 | Core finished the stepped instruction |
| core_pipe_saved | input | 1 | Core saved its pipeline and is in debug |
| pwr_state | input | PWR_W | Current power state |
| dbg_req | output | 1 | Debug request to the core |
| core_step | output | 1 | One-cycle pulse: execute one instruction |
| core_resume | output | 1 | One-cycle pulse: leave debug and resume |
| resume_pwr | output | PWR_W | Power state saved at entry |
| st_in_debug | output | 1 | Core is in debug state |
| st_session | output | 1 | Debug session is open |
| st_stepping | output | 1 | Single step in progress |
| st_go_err | output | 1 | Sticky go-without-scan-load error |
| wake | output | 1 | Wake request out of low-power states |

## Verification
The embedded assertions check the following on every cycle:
- the request is held until the core reports its pipeline saved;
- step and resume pulses never coincide and always follow a scan load;
- the error flag is sticky;
- wake covers the whole session.

Only the bench scenarios can show that the right command sequence produces the right effect. This covers a stay then exit, an ignored unarmed go, an exit absorbed by a pending request, a go while running, and simultaneous strobes. The bench also checks that the entry power state is returned on resume.

// File: rtl/dbg_session_ctrl.sv
module dbg_session_ctrl #(
  parameter int PWR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go_stay,
  input  logic             cmd_go_exit,
  input  logic             scan_loaded,
  input  logic             ext_dbg_req,
  input  logic             core_insn_done,
  input  logic             core_pipe_saved,
  input  logic [PWR_W-1:0] pwr_state,
  output logic             dbg_req,
  output logic             core_step,
  output logic             core_resume,
  output logic [PWR_W-1:0] resume_pwr,
  output logic             st_in_debug,
  output logic             st_session,
  output logic             st_stepping,
  output logic             st_go_err,
  output logic             wake
);

  typedef enum logic [1:0] {S_IDLE, S_ENTER, S_HALT, S_STEP} state_t;

  state_t           state, state_nx;
  logic             scan_ok;
  logic [PWR_W-1:0] saved_pwr;

  wire go_any      = cmd_go_stay | cmd_go_exit;
  wire halted      = (state == S_HALT);
  wire go_ok       = halted & go_any & scan_ok;
  wire go_bad      = halted & go_any & ~scan_ok;
  wire exit_ok     = go_ok & cmd_go_exit;
  wire exit_resume = exit_ok & ~ext_dbg_req;
  wire step_ok     = go_ok & ~cmd_go_exit;
  wire start_req   = (state == S_IDLE) & ext_dbg_req;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (ext_dbg_req)     state_nx = S_ENTER;
      S_ENTER: if (core_pipe_saved) state_nx = S_HALT;
      S_HALT: begin
        if (exit_resume)  state_nx = S_IDLE;
        else if (step_ok) state_nx = S_STEP;
      end
      S_STEP:  if (core_insn_done)  state_nx = S_HALT;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      scan_ok     <= 1'b0;
      st_go_err   <= 1'b0;
      saved_pwr   <= '0;
      core_step   <= 1'b0;
      core_resume <= 1'b0;
    end else begin
      state       <= state_nx;
      core_step   <= step_ok;
      core_resume <= exit_resume;
      if (scan_loaded)  scan_ok <= 1'b1;
      else if (go_ok)   scan_ok <= 1'b0;
      if (scan_loaded)  st_go_err <= 1'b0;
      else if (go_bad)  st_go_err <= 1'b1;
      if (start_req)    saved_pwr <= pwr_state;
    end
  end

  assign dbg_req     = (state == S_ENTER);
  assign st_in_debug = (state == S_HALT);
  assign st_stepping = (state == S_STEP);
  assign st_session  = (state != S_IDLE);
  assign wake        = st_session;
  assign resume_pwr  = saved_pwr;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !core_pipe_saved) |=> dbg_req);

  assert_req_not_in_debug_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> !st_in_debug);

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_step, core_resume}));

  assert_step_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_step) |-> ($past(scan_ok) && $past(cmd_go_stay) && !$past(cmd_go_exit)));

  assert_resume_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_resume |-> (!st_session && !dbg_req && $past(st_in_debug)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_go_err && !scan_loaded) |=> st_go_err);

  assert_wake_session_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_session |-> wake);

endmodule

// File: tb/test_dbg_session_ctrl.sv
module test_dbg_session_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_go_stay = 0, cmd_go_exit = 0, scan_loaded = 0, ext_dbg_req = 0;
  logic core_insn_done = 0, core_pipe_saved = 0;
  logic [1:0] pwr_state = 2'd0;
  logic dbg_req, core_step, core_resume, st_in_debug, st_session, st_stepping, st_go_err, wake;
  logic [1:0] resume_pwr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  string      tag_q[$];
  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  dbg_session_ctrl #(.PWR_W(2)) i_dbg_session_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_go_stay(cmd_go_stay), .cmd_go_exit(cmd_go_exit), .scan_loaded(scan_loaded),
    .ext_dbg_req(ext_dbg_req), .core_insn_done(core_insn_done),
    .core_pipe_saved(core_pipe_saved), .pwr_state(pwr_state),
    .dbg_req(dbg_req), .core_step(core_step), .core_resume(core_resume),
    .resume_pwr(resume_pwr), .st_in_debug(st_in_debug), .st_session(st_session),
    .st_stepping(st_stepping), .st_go_err(st_go_err), .wake(wake)
  );

  wire [9:0] got = {dbg_req, core_step, core_resume, st_in_debug, st_session,
                    st_stepping, st_go_err, wake, resume_pwr};

  // expected: {req, step, resume, in_dbg, session, stepping, err, wake, pwr}
  function automatic logic [9:0] ev(bit rq, bit sp, bit rs, bit id, bit se,
                                    bit sg, bit er, bit wk, logic [1:0] pw);
    return {rq, sp, rs, id, se, sg, er, wk, pw};
  endfunction

  task automatic expect_out(string tag, logic [9:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
  endtask

  task automatic apply(bit gs, bit gx, bit sl, bit ins, bit ps);
    cmd_go_stay = gs; cmd_go_exit = gx; scan_loaded = sl;
    core_insn_done = ins; core_pipe_saved = ps;
    @(posedge clk); #1;
    cmd_go_stay = 0; cmd_go_exit = 0; scan_loaded = 0;
    core_insn_done = 0; core_pipe_saved = 0;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      string t;
      logic [9:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      total++;
      if (got !== e) begin
        bad++;
        $display("FAIL %s got=%b exp=%b", t, got, e);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #10 rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 reset state", ev(0,0,0,0,0,0,0,0,2'd0));
    pwr_state = 2'd2; ext_dbg_req = 1;
    apply(0,0,0,0,0);
    expect_out("R2 entry request", ev(1,0,0,0,1,0,0,1,2'd2));
    apply(0,0,0,0,0);
    expect_out("R3 request held", ev(1,0,0,0,1,0,0,1,2'd2));
    ext_dbg_req = 0; pwr_state = 2'd0;
    apply(0,0,0,0,1);
    expect_out("R3 in debug after save", ev(0,0,0,1,1,0,0,1,2'd2));
    apply(1,0,0,0,0);
    expect_out("R5 stay without scan", ev(0,0,0,1,1,0,1,1,2'd2));
    apply(0,0,1,0,0);
    expect_out("R5 scan clears error", ev(0,0,0,1,1,0,0,1,2'd2));
    apply(1,0,0,0,0);
    expect_out("R4 step pulse", ev(0,1,0,0,1,1,0,1,2'd2));
    apply(0,0,0,0,0);
    expect_out("R4 stepping held", ev(0,0,0,0,1,1,0,1,2'd2));
    apply(0,0,0,1,0);
    expect_out("R4 back in debug", ev(0,0,0,1,1,0,0,1,2'd2));
    apply(0,1,0,0,0);
    expect_out("R5 exit without scan", ev(0,0,0,1,1,0,1,1,2'd2));
    apply(0,0,1,0,0);
    expect_out("R5 rearm", ev(0,0,0,1,1,0,0,1,2'd2));
    ext_dbg_req = 1;
    apply(0,1,0,0,0);
    expect_out("R7 exit with pending request", ev(0,0,0,1,1,0,0,1,2'd2));
    ext_dbg_req = 0;
    apply(0,1,0,0,0);
    expect_out("R7 token consumed", ev(0,0,0,1,1,0,1,1,2'd2));
    apply(0,0,1,0,0);
    expect_out("R5 rearm again", ev(0,0,0,1,1,0,0,1,2'd2));
    apply(0,1,0,0,0);
    expect_out("R6 resume pulse", ev(0,0,1,0,0,0,0,0,2'd2));
    apply(0,0,0,0,0);
    expect_out("R10 idle no wake", ev(0,0,0,0,0,0,0,0,2'd2));
    apply(0,0,1,0,0);
    apply(1,0,0,0,0);
    expect_out("R8 go while running", ev(0,0,0,0,0,0,0,0,2'd2));
    apply(0,1,0,0,0);
    expect_out("R8 exit while running", ev(0,0,0,0,0,0,0,0,2'd2));
    pwr_state = 2'd1; ext_dbg_req = 1;
    apply(0,0,0,0,0);
    expect_out("R2 entry from waiting", ev(1,0,0,0,1,0,0,1,2'd1));
    ext_dbg_req = 0; pwr_state = 2'd3;
    apply(0,0,0,0,1);
    expect_out("R10 wake in debug", ev(0,0,0,1,1,0,0,1,2'd1));
    apply(1,1,0,0,0);
    expect_out("R9 exit wins", ev(0,0,1,0,0,0,0,0,2'd1));
    apply(0,0,0,0,0);
    expect_out("R6 resume one cycle", ev(0,0,0,0,0,0,0,0,2'd1));
    ext_dbg_req = 1;
    apply(0,0,0,0,0);
    rst_n = 0;
    #1;
    expect_out("R1 async reset", ev(0,0,0,0,0,0,0,0,2'd0));
    ext_dbg_req = 0;
    @(negedge clk);
    @(posedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule